// File: doc/BRIEF.md
# Tile scan address generator

This block produces the read addresses that a display refresh engine needs to fetch one frame from a framebuffer held in 64 KB tiles. Each tile is 512 bytes wide and 128 lines tall. Depending on the pixel depth, a tile row therefore holds 512, 256 or 128 pixels. The tiles can sit anywhere in memory. A table in memory holds one 16-bit entry per tile, and each entry is the tile's physical address divided by 65536. The table's own base is supplied as its address divided by 512.

The generator scans the screen line by line. Within each line it visits the tile columns from left to right. When the tile under the scan changes, it first reads that tile's table entry. It then issues fixed-size burst reads that cover the line's portion of that tile. The last column may be a partial tile, and only the bytes it covers are fetched. A frame that is programmed as one whole tile wide and (width x height / pixels-per-tile-row) lines tall walks the table in order, which gives software a linear framebuffer.

A start pulse at each vertical blank restarts the scan at tile 0, line 0. The enable input is sampled only on that pulse, so turning fetching off or on takes effect at a frame boundary. A status output shows whether the current frame is actually being fetched.

Top module: `tile_scan_agen`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` and `fetch_on` are 0 until a `frame_start` pulse arrives with `enable` high.
- R2: `fetch_on` takes the value of `enable` on each `frame_start` cycle and holds it until the next one. After a start with `enable` low, no request is issued until a later start with `enable` high.
- R3: Dropping `enable` in the middle of a frame does not stop that frame. All of its requests are still issued, and `fetch_on` stays 1 until the next start.
- R4: A table read is flagged by `rd_tbl`=1. Its address is `tbl_ptr`*512 + 2*index, where index = (line/128)*cols + column. cols counts the whole tiles plus one when `part_px` is nonzero.
- R5: A burst read is flagged by `rd_tbl`=0. Its address is entry*65536 + (line mod 128)*512 + beat*`BURST_BYTES`. Beats are issued in ascending order, columns from left to right, and lines from top to bottom.
- R6: `depth` code 0 means 1 byte per pixel, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. A whole tile takes 512/`BURST_BYTES` beats per line. The partial right-hand tile (column index equal to `tiles_wide`) takes ceil(`part_px`*bytes/`BURST_BYTES`) beats per line.
- R7: The table is read only when the tile index differs from the last one read in the frame. With `tiles_wide`=1 and `part_px`=0, this means one table read per 128 lines.
- R8: A request whose `rd_ready` is low keeps `rd_valid`, `rd_addr` and `rd_tbl` unchanged in the next cycle, unless `frame_start` is high.
- R9: After the last beat of line `frame_lines`-1, no request is issued until the next `frame_start`.
- R10: `frame_start` takes priority over everything else. A request accepted in the same cycle still counts as issued. The next request is the table read for tile 0. A table response to a request made before the restart is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Fetch enable, sampled on `frame_start` |
| frame_start | input | 1 | One-cycle pulse at vertical blank start |
| tbl_ptr | input | 23 | Tile table address divided by 512 |
| tiles_wide | input | COL_W | Whole tiles across the screen |
| part_px | input | 9 | Pixel width of the partial right-hand tile, 0 if none |
| depth | input | 2 | Pixel depth code |
| frame_lines | input | LINE_W | Lines per frame |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_tbl | output | 1 | 1 = table entry read, 0 = pixel burst |
| rd_addr | output | 32 | Read byte address |
| tbl_valid | input | 1 | Table read data returned, in order |
| tbl_data | input | 16 | Returned table entry |
| fetch_on | output | 1 | Frame is being fetched |

## Verification
Two events can land in the same cycle: the restart pulse and a request handshake. The bench provokes this twice, with ready held high. The first time, it raises the start pulse one cycle after a counted handshake while bursts are streaming, so the pulse meets an accepted burst. The accepted burst must match the old frame's next expected item, and the next request must be the table read for tile 0. The second time, the pulse arrives while a table read for tile 1 is still in flight. The memory model's three-cycle latency makes that stale entry arrive while the generator waits on the new tile 0 read. The burst addresses that follow are judged against tile 0's entry.

// File: rtl/tile_scan_agen.sv
module tile_scan_agen #(
  parameter int BURST_BYTES = 64,
  parameter int LINE_W      = 12,
  parameter int COL_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frame_start,
  input  logic [22:0]       tbl_ptr,
  input  logic [COL_W-1:0]  tiles_wide,
  input  logic [8:0]        part_px,
  input  logic [1:0]        depth,
  input  logic [LINE_W-1:0] frame_lines,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              rd_tbl,
  output logic [31:0]       rd_addr,
  input  logic              tbl_valid,
  input  logic [15:0]       tbl_data,
  output logic              fetch_on
);
  localparam int NB  = 512 / BURST_BYTES;
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1;
  localparam int BSH = $clog2(BURST_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_TREQ, S_TWAIT, S_PIX} st_t;
  st_t st;

  logic [LINE_W-1:0] line;
  logic [COL_W-1:0]  tcol;
  logic [BW-1:0]     beat;
  logic [15:0]       rowbase, entry, cidx;
  logic              cval, run;
  logic [1:0]        stale;

  logic [1:0]  sh;
  logic [10:0] pbytes, pbeats, last_beat;
  logic [COL_W:0] cols;
  logic on_part, beat_end, col_end, line_end, hs, fresh, cons;
  logic [15:0] idx, n_rowbase, n_idx;
  logic [COL_W-1:0] n_tcol;

  assign sh        = (depth == 2'd0) ? 2'd0 : (depth == 2'd1) ? 2'd1 : 2'd2;
  assign pbytes    = {2'b0, part_px} << sh;
  assign pbeats    = (pbytes + 11'(BURST_BYTES - 1)) >> BSH;
  assign cols      = {1'b0, tiles_wide} + (COL_W+1)'(|part_px);
  assign on_part   = (|part_px) && (tcol == tiles_wide);
  assign last_beat = on_part ? (pbeats - 11'd1) : 11'(NB - 1);
  assign beat_end  = 11'(beat) == last_beat;
  assign col_end   = {1'b0, tcol} == (cols - (COL_W+1)'(1));
  assign line_end  = line == (frame_lines - LINE_W'(1));
  assign idx       = rowbase + 16'(tcol);
  assign n_tcol    = col_end ? '0 : tcol + COL_W'(1);
  assign n_rowbase = (col_end && line[6:0] == 7'h7f) ? rowbase + 16'(cols) : rowbase;
  assign n_idx     = n_rowbase + 16'(n_tcol);

  assign rd_valid = (st == S_TREQ) || (st == S_PIX);
  assign rd_tbl   = (st == S_TREQ);
  assign rd_addr  = rd_tbl ? ({tbl_ptr, 9'h0} + {15'h0, idx, 1'b0})
                           : ({entry, 16'h0} + {16'h0, line[6:0], 9'h0} + (32'(beat) << BSH));
  assign fetch_on = run;

  assign hs    = rd_valid && rd_ready;
  assign cons  = tbl_valid && (stale != 2'd0);
  assign fresh = tbl_valid && (stale == 2'd0) && (st == S_TWAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; run <= 1'b0; stale <= '0;
      line <= '0; tcol <= '0; beat <= '0; rowbase <= '0;
      entry <= '0; cidx <= '0; cval <= 1'b0;
    end else if (frame_start) begin
      stale   <= stale - 2'(cons) + 2'((st == S_TWAIT) && !fresh) + 2'((st == S_TREQ) && hs);
      run     <= enable;
      line    <= '0; tcol <= '0; beat <= '0; rowbase <= '0; cval <= 1'b0;
      st      <= (enable && |frame_lines) ? S_TREQ : S_IDLE;
    end else begin
      stale <= stale - 2'(cons);
      case (st)
        S_TREQ:  if (hs) st <= S_TWAIT;
        S_TWAIT: if (fresh) begin
          entry <= tbl_data; cidx <= idx; cval <= 1'b1; beat <= '0; st <= S_PIX;
        end
        S_PIX: if (hs) begin
          if (!beat_end) beat <= beat + BW'(1);
          else begin
            beat    <= '0;
            tcol    <= n_tcol;
            rowbase <= n_rowbase;
            if (col_end) line <= line + LINE_W'(1);
            if (col_end && line_end)         st <= S_IDLE;
            else if (cval && n_idx == cidx)  st <= S_PIX;
            else                             st <= S_TREQ;
          end
        end
        default: ;
      endcase
    end
  end

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !frame_start |=> rd_valid && $stable(rd_addr) && $stable(rd_tbl));
  // R2
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_on |-> !rd_valid);
  // R2
  latch_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> fetch_on == $past(enable));
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && enable && (|frame_lines) |=> rd_valid && rd_tbl && rd_addr == {$past(tbl_ptr), 9'h0});
  // R10
  stale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stale != 2'd3);
endmodule

// File: tb/tile_scan_agen_tb.sv
module tile_scan_agen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0, frame_start = 1'b0;
  logic [22:0] tbl_ptr = '0;
  logic [5:0] tiles_wide = '0;
  logic [8:0] part_px = '0;
  logic [1:0] depth = '0;
  logic [11:0] frame_lines = '0;
  logic rd_valid, rd_tbl, fetch_on;
  logic rd_ready = 1'b1;
  logic [31:0] rd_addr;
  logic tbl_valid = 1'b0;
  logic [15:0] tbl_data = '0;

  tile_scan_agen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
    .tbl_ptr(tbl_ptr), .tiles_wide(tiles_wide), .part_px(part_px), .depth(depth),
    .frame_lines(frame_lines), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_tbl(rd_tbl),
    .rd_addr(rd_addr), .tbl_valid(tbl_valid), .tbl_data(tbl_data), .fetch_on(fetch_on));

  typedef struct { logic tbl; logic [31:0] addr; string tag; } item_t;
  item_t q[$];
  int total = 0, bad = 0, hs_n = 0, tbl_hs_n = 0;
  logic cap_v = 1'b0; logic [31:0] cap_a = '0;
  logic stall = 1'b0; logic [7:0] lfsr = 8'h5b;
  logic p0v = 0, p1v = 0, p2v = 0; logic [15:0] p0d = 0, p1d = 0, p2d = 0;

  function automatic logic [15:0] tdata(input logic [31:0] a);
    return 16'h0100 + 16'(a[12:1]) * 16'd5;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    item_t it;
    if (rst_n && rd_valid && rd_ready) begin
      hs_n++;
      if (rd_tbl) begin tbl_hs_n++; cap_v = 1'b1; cap_a = rd_addr; end
      if (q.size() == 0) check(0, "R9", "unexpected request", rd_addr, 32'h0);
      else begin
        it = q.pop_front();
        check(rd_tbl == it.tbl && rd_addr == it.addr, it.tag,
              it.tbl ? "table read" : "burst read", {rd_addr[31:1], rd_tbl}, {it.addr[31:1], it.tbl});
      end
    end
  end

  initial begin : memory
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_ready = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
      p2v = p1v; p2d = p1d; p1v = p0v; p1d = p0d;
      p0v = cap_v; p0d = tdata(cap_a); cap_v = 1'b0;
      tbl_valid = p2v; tbl_data = p2d;
    end
  end

  task automatic push(input logic t, input logic [31:0] a, input string tag);
    item_t it;
    it.tbl = t; it.addr = a; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic push_frame(input string ptag, input string ttag);
    int cols, bpp, nbp, cached, idx, nb;
    logic [31:0] ta; logic [15:0] ent;
    cols = int'(tiles_wide) + (part_px != 0 ? 1 : 0);
    bpp = (depth == 0) ? 1 : (depth == 1) ? 2 : 4;
    nbp = (int'(part_px) * bpp + 63) / 64;
    cached = -1; ent = '0;
    for (int ln = 0; ln < int'(frame_lines); ln++)
      for (int c = 0; c < cols; c++) begin
        idx = (ln / 128) * cols + c;
        if (idx != cached) begin
          ta = {tbl_ptr, 9'h0} + 32'(idx * 2);
          push(1'b1, ta, ttag);
          ent = tdata(ta); cached = idx;
        end
        nb = (c == int'(tiles_wide)) ? nbp : 8;
        for (int b = 0; b < nb; b++)
          push(1'b0, {ent, 16'h0} + 32'((ln % 128) * 512 + b * 64), ptag);
      end
  endtask

  task automatic cfg(input logic [22:0] p, input logic [5:0] tw, input logic [8:0] pp,
                     input logic [1:0] d, input logic [11:0] l);
    @(posedge clk); #1;
    tbl_ptr = p; tiles_wide = tw; part_px = pp; depth = d; frame_lines = l;
  endtask

  task automatic start_frame(input logic en);
    @(posedge clk); #1; enable = en; frame_start = 1'b1;
    @(posedge clk); #1; frame_start = 1'b0;
  endtask

  task automatic drain(input string tag);
    int h;
    wait (q.size() == 0);
    h = hs_n;
    repeat (20) @(negedge clk);
    check(hs_n == h, tag, "requests after frame end", hs_n, h);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int h;
    repeat (3) @(negedge clk);
    check(!rd_valid, "R1", "valid in reset", rd_valid, 0);
    check(!fetch_on, "R1", "fetch_on in reset", fetch_on, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!rd_valid && !fetch_on, "R1", "idle after reset", {rd_valid, fetch_on}, 0);

    // R4 R5 R6 R8: two whole tiles plus partial, tile-row crossing, stalls
    stall = 1'b1;
    cfg(23'h000123, 6'd2, 9'd40, 2'd1, 12'd130);
    push_frame("R5", "R4");
    start_frame(1'b1);
    drain("R9");
    stall = 1'b0;

    // R7: linear layout, one table read per 128 lines
    cfg(23'h000400, 6'd1, 9'd0, 2'd2, 12'd260);
    push_frame("R7", "R7");
    h = tbl_hs_n;
    start_frame(1'b1);
    drain("R9");
    check(tbl_hs_n - h == 3, "R7", "table reads in linear frame", tbl_hs_n - h, 3);

    // R6: depth codes and partial widths
    cfg(23'h000010, 6'd1, 9'd33, 2'd3, 12'd3);
    push_frame("R6", "R4"); start_frame(1'b1); drain("R6");
    cfg(23'h000020, 6'd0, 9'd100, 2'd0, 12'd2);
    push_frame("R6", "R4"); start_frame(1'b1); drain("R6");
    cfg(23'h000030, 6'd1, 9'd16, 2'd2, 12'd2);
    push_frame("R6", "R4"); start_frame(1'b1); drain("R6");

    // R3: enable dropped mid-frame
    cfg(23'h000040, 6'd1, 9'd0, 2'd0, 12'd3);
    push_frame("R3", "R3");
    start_frame(1'b1);
    repeat (6) @(posedge clk); #1 enable = 1'b0;
    drain("R3");
    check(fetch_on, "R3", "fetch_on kept until next start", fetch_on, 1);

    // R2: start with enable low, then high again
    start_frame(1'b0);
    @(negedge clk);
    check(!fetch_on, "R2", "fetch_on after disabled start", fetch_on, 0);
    h = hs_n;
    repeat (40) @(negedge clk);
    check(hs_n == h, "R2", "requests while disabled", hs_n, h);
    push_frame("R2", "R2");
    start_frame(1'b1);
    @(negedge clk);
    check(fetch_on, "R2", "fetch_on after enabled start", fetch_on, 1);
    drain("R2");

    // R10: restart colliding with an accepted burst
    cfg(23'h000050, 6'd2, 9'd0, 2'd0, 12'd4);
    push_frame("R5", "R4");
    h = hs_n;
    start_frame(1'b1);
    wait (hs_n == h + 12);
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
    q.delete();
    push_frame("R10", "R10");
    drain("R10");

    // R10: restart with a table read for tile 1 in flight
    push_frame("R5", "R4");
    h = tbl_hs_n;
    start_frame(1'b1);
    wait (tbl_hs_n == h + 2);
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
    q.delete();
    push_frame("R10", "R10");
    drain("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule